// File: doc/BRIEF.md
# SDRAM Low-Power and Refresh Sequencer

This block sequences refresh and low-power commands for an SDRAM controller. Software writes a small control word with two bits: a clock-enable request and a refresh-enable request. From these the block drives the memory clock-enable pin and issues one command per cycle on an encoded command output. The commands are no-operation, precharge-all, auto-refresh, self-refresh entry and power-down entry. The block owns the refresh-interval down-counter and a pending-refresh flag. It decides between self-refresh and power-down when the memory is put to sleep. On wake-up it inserts a settling gap and a catch-up refresh when one is needed.

A write is sampled on a clock edge where `ctl_wr` is high. A write is *applied* on the next edge at which the sequencer is in a resting state (active, self-refresh or power-down). Any command that the write causes appears on `mem_cmd` right after that apply edge. A write that arrives while a multi-cycle sequence runs is held, and a later write replaces it. Command codes on `mem_cmd`: 0 = NOP, 1 = precharge-all, 2 = auto-refresh, 3 = self-refresh entry, 4 = power-down entry.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset `mem_cke` is 1, `mem_cmd` is NOP (0) and refresh is disabled.
- R2: While active with refresh enabled, the block issues precharge-all (1) followed on the next cycle by auto-refresh (2). It repeats this pair every REF_INTERVAL cycles. The first precharge-all comes REF_INTERVAL+1 cycles after the apply edge of the enabling write.
- R3: An applied write with clock-enable 0 and refresh-enable 1 gives precharge-all on the apply cycle and self-refresh entry (3) on the next cycle. `mem_cke` goes low in the self-refresh entry cycle, stays low while asleep, and no further command is issued while asleep.
- R4: An applied write with clock-enable 0 and refresh-enable 0 gives a lone power-down entry (4) with `mem_cke` low in that same cycle and no precharge-all before it.
- R5: The sleep mode is chosen by the refresh-enable value carried in the same write that clears clock-enable, not by the previous setting.
- R6: An applied write with clock-enable 1 while asleep raises `mem_cke` on the apply cycle. Exactly EXIT_NOPS NOP cycles then follow before any command.
- R7: If a refresh interval expired during self-refresh, the wake-up issues precharge-all then auto-refresh right after the EXIT_NOPS gap. Only one such pair is issued, however many intervals expired.
- R8: If self-refresh is entered and left within one interval, no catch-up pair is issued and the next periodic refresh keeps its original schedule.
- R9: Clearing refresh-enable during self-refresh resets the interval counter and drops any pending refresh. A later wake-up that re-enables refresh issues no catch-up, and the first refresh follows the R2 timing from that wake-up's apply edge.
- R10: No precharge-all or auto-refresh is issued while refresh-enable is 0.
- R11: Writes that arrive during a multi-cycle sequence are held until the sequencer rests, and only the most recent of them is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_cke | input | 1 | Written clock-enable request |
| ctl_ref_en | input | 1 | Written refresh-enable request |
| mem_cke | output | 1 | Memory clock-enable pin |
| mem_cmd | output | 3 | Encoded memory command (0 NOP, 1 precharge-all, 2 refresh, 3 self-refresh entry, 4 power-down entry) |

## Verification
The bench builds the block with REF_INTERVAL = 40 and EXIT_NOPS = 3. A 40-cycle interval lets one run cover several periodic refreshes and a self-refresh stay of more than two intervals, which is needed to show that only one catch-up pair is issued. It also allows a short stay that ends before the first expiry, which shows the periodic schedule is kept. Three exit NOPs make the wake-up window wide enough to put two overlapping writes inside it, so the check can show that the later write replaces the earlier one.

// File: rtl/sdlp_pkg.sv
package sdlp_pkg;

    // Encoded command strobe; one command per cycle, NOP by default.
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PALL = 3'd1,
        CMD_REF  = 3'd2,
        CMD_SREF = 3'd3,
        CMD_PDWN = 3'd4
    } sd_cmd_e;

    // Software control word.
    typedef struct packed {
        logic cke;
        logic ref_en;
    } lp_ctl_t;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_ACT   = 3'd0,   // memory awake, periodic refresh possible
        ST_RPALL = 3'd1,   // precharge-all issued, auto-refresh next
        ST_EPALL = 3'd2,   // precharge-all issued, self-refresh entry next
        ST_SREF  = 3'd3,   // asleep in self-refresh
        ST_PDWN  = 3'd4,   // asleep in power-down
        ST_WAKE  = 3'd5    // clock enabled again, settling NOPs
    } seq_st_e;

    localparam lp_ctl_t CTL_RESET = '{cke: 1'b1, ref_en: 1'b0};

    // A resting state may accept a held control write.
    function automatic logic st_is_rest(seq_st_e st);
        return (st == ST_ACT) || (st == ST_SREF) || (st == ST_PDWN);
    endfunction

    // Resting states in which the memory sleeps.
    function automatic logic st_is_sleep(seq_st_e st);
        return (st == ST_SREF) || (st == ST_PDWN);
    endfunction

    // Commands that count as a completed refresh.
    function automatic logic cmd_refreshes(sd_cmd_e c);
        return (c == CMD_REF) || (c == CMD_SREF);
    endfunction

    // Sleep command chosen by the refresh-enable bit of the sleeping write.
    function automatic sd_cmd_e sleep_cmd(lp_ctl_t w);
        return w.ref_en ? CMD_PALL : CMD_PDWN;
    endfunction

endpackage

// File: rtl/sdlp_ctl_hold.sv
module sdlp_ctl_hold
    import sdlp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  lp_ctl_t wr_val,
    input  logic    accept,
    output logic    held_vld,
    output lp_ctl_t held_val
);

    logic    vld_q;
    lp_ctl_t val_q;

    // A new write always wins over an accept in the same cycle, so the
    // most recent write is never lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            val_q <= CTL_RESET;
        end else begin
            if (wr_en) begin
                vld_q <= 1'b1;
                val_q <= wr_val;
            end else if (accept) begin
                vld_q <= 1'b0;
            end
        end
    end

    assign held_vld = vld_q;
    assign held_val = val_q;

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !accept && !wr_en) |=> (vld_q && $stable(val_q))); // R11

    AST_HOLD_LATEST: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (vld_q && val_q == $past(wr_val))); // R11

    AST_ACCEPT_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        accept |-> vld_q); // R11

endmodule

// File: rtl/sdlp_ref_timer.sv
module sdlp_ref_timer
    import sdlp_pkg::*;
#(
    parameter int REF_INTERVAL = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_en,
    input  logic ack,
    output logic due
);

    localparam int CW = $clog2(REF_INTERVAL + 1);
    localparam logic [CW-1:0] RELOAD = CW'(REF_INTERVAL - 1);

    logic [CW-1:0] cnt_q;
    logic          due_q;
    logic          expire;

    assign expire = (cnt_q == '0);

    // Down-counter reloaded on expiry; clearing the enable resets it and
    // drops any refresh that was still owed.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RELOAD;
            due_q <= 1'b0;
        end else if (!ref_en) begin
            cnt_q <= RELOAD;
            due_q <= 1'b0;
        end else begin
            cnt_q <= expire ? RELOAD : cnt_q - 1'b1;
            if (expire) begin
                due_q <= 1'b1;
            end else if (ack) begin
                due_q <= 1'b0;
            end
        end
    end

    assign due = due_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= RELOAD); // R2

    AST_DUE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> !due_q); // R10

    AST_DUE_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(due_q) |-> ($past(ref_en) && $past(cnt_q) == '0)); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && ref_en && !expire) |=> !due_q); // R7

endmodule

// File: rtl/sdlp_seq_fsm.sv
module sdlp_seq_fsm
    import sdlp_pkg::*;
#(
    parameter int EXIT_NOPS = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    held_vld,
    input  lp_ctl_t held_val,
    input  logic    ref_due,
    output logic    accept,
    output logic    ref_ack,
    output logic    ref_en,
    output sd_cmd_e cmd_o,
    output logic    cke_o
);

    localparam int NOPS = (EXIT_NOPS < 1) ? 1 : EXIT_NOPS;
    localparam int WW   = $clog2(NOPS + 1);
    localparam logic [WW-1:0] WAKE_LOAD = WW'(NOPS - 1);

    seq_st_e       st_q,   st_d;
    sd_cmd_e       cmd_q,  cmd_d;
    logic          cke_q,  cke_d;
    lp_ctl_t       ctl_q,  ctl_d;
    logic [WW-1:0] wcnt_q, wcnt_d;

    always_comb begin
        st_d    = st_q;
        cmd_d   = CMD_NOP;
        cke_d   = cke_q;
        ctl_d   = ctl_q;
        wcnt_d  = wcnt_q;
        accept  = 1'b0;
        ref_ack = 1'b0;
        unique case (st_q)
            ST_ACT: begin
                if (held_vld) begin
                    accept = 1'b1;
                    ctl_d  = held_val;
                    if (!held_val.cke) begin
                        // Sleep mode follows the refresh bit of this write.
                        cmd_d = sleep_cmd(held_val);
                        if (held_val.ref_en) begin
                            st_d = ST_EPALL;
                        end else begin
                            st_d  = ST_PDWN;
                            cke_d = 1'b0;
                        end
                    end
                end else if (ref_due && ctl_q.ref_en) begin
                    st_d  = ST_RPALL;
                    cmd_d = CMD_PALL;
                end
            end
            ST_RPALL: begin
                cmd_d   = CMD_REF;
                ref_ack = 1'b1;
                st_d    = ST_ACT;
            end
            ST_EPALL: begin
                cmd_d   = CMD_SREF;
                ref_ack = 1'b1;
                cke_d   = 1'b0;
                st_d    = ST_SREF;
            end
            ST_SREF, ST_PDWN: begin
                if (held_vld) begin
                    accept = 1'b1;
                    ctl_d  = held_val;
                    if (held_val.cke) begin
                        cke_d  = 1'b1;
                        wcnt_d = WAKE_LOAD;
                        st_d   = ST_WAKE;
                    end
                end
            end
            ST_WAKE: begin
                if (wcnt_q == '0) begin
                    if (ref_due) begin
                        cmd_d = CMD_PALL;
                        st_d  = ST_RPALL;
                    end else begin
                        st_d = ST_ACT;
                    end
                end else begin
                    wcnt_d = wcnt_q - 1'b1;
                end
            end
            default: begin
                st_d = ST_ACT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_ACT;
            cmd_q  <= CMD_NOP;
            cke_q  <= 1'b1;
            ctl_q  <= CTL_RESET;
            wcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            cmd_q  <= cmd_d;
            cke_q  <= cke_d;
            ctl_q  <= ctl_d;
            wcnt_q <= wcnt_d;
        end
    end

    assign cmd_o  = cmd_q;
    assign cke_o  = cke_q;
    assign ref_en = ctl_q.ref_en;

    AST_SREF_AFTER_PALL: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_SREF) |-> ($past(cmd_q) == CMD_PALL)); // R3

    AST_REF_AFTER_PALL: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_REF) |-> ($past(cmd_q) == CMD_PALL)); // R2

    AST_ENTRY_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_SREF || cmd_q == CMD_PDWN) |-> !cke_q); // R4

    AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (!cke_q && !$past(cke_q)) |-> (cmd_q == CMD_NOP)); // R3

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAKE) |-> (cmd_q == CMD_NOP && cke_q)); // R6

    AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_q) |-> (cmd_q == CMD_NOP && $past(st_is_sleep(st_q)))); // R6

    AST_NO_REF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACT && !ctl_q.ref_en && !held_vld) |=> (cmd_q == CMD_NOP)); // R10

    AST_ACCEPT_AT_REST: assert property (@(posedge clk) disable iff (rst)
        accept |-> st_is_rest(st_q)); // R11

    AST_ACK_ON_REFRESH: assert property (@(posedge clk) disable iff (rst)
        ref_ack |=> cmd_refreshes(cmd_q)); // R7

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
    import sdlp_pkg::*;
#(
    parameter int REF_INTERVAL = 780,
    parameter int EXIT_NOPS    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic       ctl_cke,
    input  logic       ctl_ref_en,
    output logic       mem_cke,
    output logic [2:0] mem_cmd
);

    lp_ctl_t wr_val;
    lp_ctl_t held_val;
    logic    held_vld;
    logic    accept;
    logic    ref_ack;
    logic    ref_en;
    logic    ref_due;
    sd_cmd_e cmd;

    assign wr_val = '{cke: ctl_cke, ref_en: ctl_ref_en};

    sdlp_ctl_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctl_wr),
        .wr_val   (wr_val),
        .accept   (accept),
        .held_vld (held_vld),
        .held_val (held_val)
    );

    sdlp_ref_timer #(
        .REF_INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .ref_en (ref_en),
        .ack    (ref_ack),
        .due    (ref_due)
    );

    sdlp_seq_fsm #(
        .EXIT_NOPS (EXIT_NOPS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .held_vld (held_vld),
        .held_val (held_val),
        .ref_due  (ref_due),
        .accept   (accept),
        .ref_ack  (ref_ack),
        .ref_en   (ref_en),
        .cmd_o    (cmd),
        .cke_o    (mem_cke)
    );

    assign mem_cmd = cmd;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (mem_cke && mem_cmd == 3'd0)); // R1

endmodule

// File: tb/sdram_lp_seq_tb_top.sv
module sdram_lp_seq_tb_top;
    import sdlp_pkg::*;

    localparam int IV = 40;
    localparam int NX = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic       ctl_cke = 1'b1;
    logic       ctl_ref_en = 1'b0;
    logic       mem_cke;
    logic [2:0] mem_cmd;

    sdram_lp_seq #(.REF_INTERVAL(IV), .EXIT_NOPS(NX)) dut_i (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_cke(ctl_cke),
        .ctl_ref_en(ctl_ref_en), .mem_cke(mem_cke), .mem_cmd(mem_cmd)
    );

    always #4 clk = ~clk;  // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    cmd;
        int    at;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    n_chk = 0;
    int    n_fail = 0;
    string seg_tag = "R10";
    bit    done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)",
                     tag, what, act, expv, cyc);
        end
    endtask

    function automatic void expect_cmd(input sd_cmd_e c, input int at, input string tag);
        exp_t e;
        e.cmd = int'(c);
        e.at  = at;
        e.tag = tag;
        sb.push_back(e);
    endfunction

    // Monitor: every non-NOP command must match the next expected item.
    always @(negedge clk) begin
        if (!rst && !done && mem_cmd != 3'd0) begin
            if (sb.size() == 0) begin
                check(1'b0, seg_tag, "unexpected command", int'(mem_cmd), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(mem_cmd) == e.cmd, e.tag, "command code", int'(mem_cmd), e.cmd);
                check(cyc == e.at, e.tag, "command cycle", cyc, e.at);
            end
        end
    end

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wr(input logic cke, input logic ren, output int w);
        ctl_wr = 1'b1;
        ctl_cke = cke;
        ctl_ref_en = ren;
        @(negedge clk);
        w = cyc;
        ctl_wr = 1'b0;
    endtask

    task automatic drain(input string tag);
        check(sb.size() == 0, tag, "expected commands left", sb.size(), 0);
        sb.delete();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ctl_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        sb.delete();
    endtask

    task automatic chk_cke(input int t, input logic v, input string tag);
        wait_to(t);
        check(mem_cke == v, tag, "mem_cke", int'(mem_cke), int'(v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w, w2, b;
        @(negedge clk);
        do_reset();

        // R1: reset state; R10: nothing issued while refresh is disabled
        check(mem_cke == 1'b1, "R1", "mem_cke after reset", int'(mem_cke), 1);
        check(mem_cmd == 3'd0, "R1", "mem_cmd after reset", int'(mem_cmd), 0);
        seg_tag = "R10";
        b = cyc;
        wait_to(b + 3 * IV);
        drain("R10");

        // R2: periodic precharge-all + refresh
        do_reset();
        seg_tag = "R2";
        wr(1'b1, 1'b1, w);
        for (int k = 1; k <= 3; k++) begin
            expect_cmd(CMD_PALL, w + k * IV + 2, "R2");
            expect_cmd(CMD_REF,  w + k * IV + 3, "R2");
        end
        wait_to(w + 3 * IV + 8);
        drain("R2");

        // R3/R5: sleep with refresh bit set in the same write -> self-refresh;
        // R6/R8: short stay, no catch-up, schedule kept
        do_reset();
        seg_tag = "R8";
        wr(1'b0, 1'b1, w);
        expect_cmd(CMD_PALL, w + 1, "R3");
        expect_cmd(CMD_SREF, w + 2, "R5");
        chk_cke(w + 1, 1'b1, "R3");
        chk_cke(w + 2, 1'b0, "R3");
        chk_cke(w + 10, 1'b0, "R3");
        wait_to(w + 13);
        wr(1'b1, 1'b1, w2);
        chk_cke(w2 + 1, 1'b1, "R6");
        expect_cmd(CMD_PALL, w + IV + 2, "R8");
        expect_cmd(CMD_REF,  w + IV + 3, "R8");
        wait_to(w + IV + 8);
        drain("R8");

        // R7: long self-refresh, exactly one catch-up pair after the NOP gap
        do_reset();
        seg_tag = "R7";
        wr(1'b0, 1'b1, w);
        expect_cmd(CMD_PALL, w + 1, "R3");
        expect_cmd(CMD_SREF, w + 2, "R3");
        wait_to(w + 99);
        wr(1'b1, 1'b1, w2);
        chk_cke(w2, 1'b0, "R7");
        expect_cmd(CMD_PALL, w2 + 1 + NX, "R7");
        expect_cmd(CMD_REF,  w2 + 2 + NX, "R7");
        expect_cmd(CMD_PALL, w + 3 * IV + 2, "R7");
        expect_cmd(CMD_REF,  w + 3 * IV + 3, "R7");
        chk_cke(w2 + 1, 1'b1, "R6");
        wait_to(w + 3 * IV + 8);
        drain("R7");

        // R4: power-down, no precharge-all, later wake with refresh off
        do_reset();
        seg_tag = "R4";
        wr(1'b0, 1'b0, w);
        expect_cmd(CMD_PDWN, w + 1, "R4");
        chk_cke(w, 1'b1, "R4");
        chk_cke(w + 1, 1'b0, "R4");
        wait_to(w + 60);
        wr(1'b1, 1'b0, w2);
        chk_cke(w2, 1'b0, "R6");
        chk_cke(w2 + 1, 1'b1, "R6");
        wait_to(w2 + 2 * IV);
        drain("R4");

        // R5: refresh was on, same write clears it -> power-down
        do_reset();
        seg_tag = "R5";
        wr(1'b1, 1'b1, w);
        wait_to(w + 4);
        wr(1'b0, 1'b0, w2);
        expect_cmd(CMD_PDWN, w2 + 1, "R5");
        chk_cke(w2 + 1, 1'b0, "R5");
        wait_to(w2 + 2 * IV);
        drain("R5");

        // R9: clear refresh during self-refresh, wake re-enabling it
        do_reset();
        seg_tag = "R9";
        wr(1'b0, 1'b1, w);
        expect_cmd(CMD_PALL, w + 1, "R9");
        expect_cmd(CMD_SREF, w + 2, "R9");
        wait_to(w + 19);
        wr(1'b0, 1'b0, b);
        chk_cke(w + 25, 1'b0, "R9");
        wait_to(w + 149);
        wr(1'b1, 1'b1, w2);
        expect_cmd(CMD_PALL, w2 + IV + 2, "R9");
        expect_cmd(CMD_REF,  w2 + IV + 3, "R9");
        wait_to(w2 + IV + 8);
        drain("R9");

        // R11: write held through a busy sequence; latest held write wins
        do_reset();
        seg_tag = "R11";
        wr(1'b0, 1'b1, w);
        wr(1'b1, 1'b1, b);
        expect_cmd(CMD_PALL, w + 1, "R11");
        expect_cmd(CMD_SREF, w + 2, "R11");
        chk_cke(w + 2, 1'b0, "R11");
        chk_cke(w + 3, 1'b1, "R11");
        wr(1'b1, 1'b0, b);
        wr(1'b0, 1'b0, b);
        expect_cmd(CMD_PDWN, w + 7, "R11");
        chk_cke(w + 6, 1'b1, "R11");
        chk_cke(w + 7, 1'b0, "R11");
        wait_to(w + 2 * IV + 8);
        drain("R11");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule